// File: doc/BRIEF.md
# Program Sequencer with Halt Counter

This block is the instruction-sequencing unit of a small single-cycle processor. Every clock edge retires one instruction. On that edge the block picks the next fetch address: the sequential successor, or a resolved branch or jump target supplied by decode. It also loads the condition flags that the executing instruction updates, and it counts retired instructions.

When decode signals a halt, the processor stops and the halted status rises. From then on the program counter, the flags and the instruction count all hold until the next reset. The halt instruction is itself counted.

A synchronous reset clears the program counter and the count and loads the flags with a parameterised value. The block has no output towards the general-purpose register file, so reset never alters register contents. Decode, the ALU, the register file and the memories sit outside this block.

Top module: `prog_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, that edge sets `pc` to 0, `instrCount` to 0, `halted` to 0 and `flags` to the parameter `FLAG_RST`.
- R2: On an executing edge (`rst` low, `halted` low) with `haltReq` and `xferTaken` both low, `pc` becomes `pc + 1` modulo 2^`PC_W`, so the highest address wraps to 0.
- R3: On an executing edge with `xferTaken` high and `haltReq` low, `pc` loads `xferTarget`.
- R4: On an executing edge with `haltReq` high, `halted` becomes 1 and `pc` keeps its value, even when `xferTaken` is high in the same cycle.
- R5: Once `halted` is 1 it stays 1 until reset. While it is 1, `pc`, `flags` and `instrCount` hold, whatever the strobe, target and flag inputs are.
- R6: Each executing edge adds one to `instrCount`. The edge that executes the halt is included.
- R7: `instrCount` saturates at 2^`CNT_W` - 1 and does not wrap.
- R8: On an executing edge, bit i of `flags` loads `flagIn[i]` when `flagWe[i]` is 1 and keeps its value when `flagWe[i]` is 0. The executing halt edge also applies its flag writes.
- R9: Reset takes priority over every other input, including a halted state. After reset is released, execution resumes from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| xferTaken | input | 1 | Taken branch or jump in the current instruction |
| xferTarget | input | PC_W | Address loaded when the transfer is taken |
| haltReq | input | 1 | Current instruction is a halt |
| flagWe | input | FLAG_W | Per-flag write enables from the current instruction |
| flagIn | input | FLAG_W | New flag values |
| pc | output | PC_W | Current fetch address |
| halted | output | 1 | Processor has executed a halt |
| flags | output | FLAG_W | Condition flags |
| instrCount | output | CNT_W | Retired-instruction count |

## Verification
The bench keeps `PC_W` at its default of 8, so a run of sequential steps from a jump target near the top of the address space reaches the wrap from 255 to 0 within a few dozen cycles. It sets `CNT_W` to 6, which brings counter saturation at 63 within about seventy executed instructions and leaves time for further steps that show the count pinned. It uses `FLAG_RST` = 4'b1010 so that the reset value of the flags differs from all-zero and from all-one.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic pcStep;   // advance to the sequential successor
    logic pcLoad;   // load the transfer target
    logic tick;     // an instruction retires on this edge
  } seqCtrl_t;

endpackage

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     haltReq,
  input  logic     xferTaken,
  output seqCtrl_t ctrl,
  output logic     halted
);

  logic running;

  assign running = !halted;

  // Halt wins over a taken transfer; nothing moves once halted
  always_comb begin
    ctrl        = '0;
    ctrl.tick   = running;
    ctrl.pcLoad = running && !haltReq && xferTaken;
    ctrl.pcStep = running && !haltReq && !xferTaken;
  end

  always_ff @(posedge clk) begin
    if (rst)
      halted <= 1'b0;
    else if (running && haltReq)
      halted <= 1'b1;
  end

  // R4
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && haltReq) |=> halted);

  // R5
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R4
  halt_no_move_chk: assert property (@(posedge clk) disable iff (rst)
    haltReq |-> !(ctrl.pcStep || ctrl.pcLoad));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int                PC_W     = 8,
  parameter int                CNT_W    = 16,
  parameter int                FLAG_W   = 4,
  parameter logic [FLAG_W-1:0] FLAG_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtrl_t          ctrl,
  input  logic [PC_W-1:0]   xferTarget,
  input  logic [FLAG_W-1:0] flagWe,
  input  logic [FLAG_W-1:0] flagIn,
  output logic [PC_W-1:0]   pc,
  output logic [FLAG_W-1:0] flags,
  output logic [CNT_W-1:0]  instrCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PC_W-1:0]  PC_ONE  = PC_W'(1);

  logic [PC_W-1:0] pcNext;
  logic            cntAtMax;

  // Next fetch address: successor, target, or hold
  always_comb begin
    pcNext = pc;
    if (ctrl.pcLoad)
      pcNext = xferTarget;
    else if (ctrl.pcStep)
      pcNext = pc + PC_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pc <= '0;
    else
      pc <= pcNext;
  end

  // Saturating retired-instruction counter
  assign cntAtMax = (instrCount == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)
      instrCount <= '0;
    else if (ctrl.tick && !cntAtMax)
      instrCount <= instrCount + CNT_W'(1);
  end

  // One flop per flag, each with its own write enable
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[i] <= FLAG_RST[i];
      else if (ctrl.tick && flagWe[i])
        flags[i] <= flagIn[i];
    end

    // R8
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl.tick && flagWe[i]) |=> (flags[i] == $past(flagIn[i])));

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !(ctrl.tick && flagWe[i]) |=> $stable(flags[i]));
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && instrCount == '0 && flags == FLAG_RST));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.pcStep |=> (pc == PC_W'($past(pc) + PC_ONE)));

  // R3
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.pcLoad |=> (pc == $past(xferTarget)));

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.pcStep || ctrl.pcLoad) |=> $stable(pc));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.tick && instrCount != CNT_MAX) |=>
      (instrCount == CNT_W'($past(instrCount) + CNT_W'(1))));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (instrCount == CNT_MAX) |=> (instrCount == CNT_MAX));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.tick |=> $stable(instrCount));

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer #(
  parameter int                PC_W     = 8,
  parameter int                CNT_W    = 16,
  parameter int                FLAG_W   = 4,
  parameter logic [FLAG_W-1:0] FLAG_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xferTaken,
  input  logic [PC_W-1:0]   xferTarget,
  input  logic              haltReq,
  input  logic [FLAG_W-1:0] flagWe,
  input  logic [FLAG_W-1:0] flagIn,
  output logic [PC_W-1:0]   pc,
  output logic              halted,
  output logic [FLAG_W-1:0] flags,
  output logic [CNT_W-1:0]  instrCount
);

  seq_pkg::seqCtrl_t ctrl;

  seq_control u_control (
    .clk       (clk),
    .rst       (rst),
    .haltReq   (haltReq),
    .xferTaken (xferTaken),
    .ctrl      (ctrl),
    .halted    (halted)
  );

  seq_datapath #(
    .PC_W     (PC_W),
    .CNT_W    (CNT_W),
    .FLAG_W   (FLAG_W),
    .FLAG_RST (FLAG_RST)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .xferTarget (xferTarget),
    .flagWe     (flagWe),
    .flagIn     (flagIn),
    .pc         (pc),
    .flags      (flags),
    .instrCount (instrCount)
  );

endmodule

// File: tb/prog_sequencer_test.sv
`timescale 1ns/1ps
module prog_sequencer_test;

  localparam int         PC_W     = 8;
  localparam int         CNT_W    = 6;
  localparam int         FLAG_W   = 4;
  localparam logic [3:0] FLAG_RST = 4'b1010;
  localparam int         PC_MOD   = 1 << PC_W;
  localparam int         CNT_TOP  = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              xferTaken = 1'b0;
  logic [PC_W-1:0]   xferTarget = '0;
  logic              haltReq = 1'b0;
  logic [FLAG_W-1:0] flagWe = '0;
  logic [FLAG_W-1:0] flagIn = '0;
  logic [PC_W-1:0]   pc;
  logic              halted;
  logic [FLAG_W-1:0] flags;
  logic [CNT_W-1:0]  instrCount;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // Behavioural reference state
  int mPc     = 0;
  int mCnt    = 0;
  bit mHalted = 0;
  int mFlags  = 0;

  always #2 clk = ~clk;

  prog_sequencer #(
    .PC_W(PC_W), .CNT_W(CNT_W), .FLAG_W(FLAG_W), .FLAG_RST(FLAG_RST)
  ) uut (
    .clk(clk), .rst(rst), .xferTaken(xferTaken), .xferTarget(xferTarget),
    .haltReq(haltReq), .flagWe(flagWe), .flagIn(flagIn), .pc(pc),
    .halted(halted), .flags(flags), .instrCount(instrCount)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic void modelEdge(bit r, bit xf, int tgt, bit hr, int we, int fi);
    if (r) begin
      mPc = 0; mCnt = 0; mHalted = 0; mFlags = int'(FLAG_RST);
    end else if (!mHalted) begin
      if (hr)      mHalted = 1;
      else if (xf) mPc = tgt;
      else         mPc = (mPc + 1) % PC_MOD;
      if (mCnt < CNT_TOP) mCnt++;
      mFlags = (mFlags & ~we) | (fi & we);
    end
  endfunction

  // Drive away from the edge, let the edge pass, then compare
  task automatic step(string req, bit r, bit xf, int tgt, bit hr, int we, int fi);
    @(negedge clk);
    rst = r; xferTaken = xf; xferTarget = PC_W'(tgt); haltReq = hr;
    flagWe = FLAG_W'(we); flagIn = FLAG_W'(fi);
    @(posedge clk);
    modelEdge(r, xf, tgt, hr, we & 15, fi & 15);
    #1;
    check(req, "pc", int'(pc), mPc);
    check(req, "halted", int'(halted), int'(mHalted));
    check(req, "flags", int'(flags), mFlags);
    check(req, "instrCount", int'(instrCount), mCnt);
  endtask

  task automatic finishUp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishUp();
    end
  end

  initial begin
    // R1: reset state
    step("R1", 1, 0, 0, 0, 0, 0);
    step("R1", 1, 1, 77, 1, 15, 5);

    // R2 / R8: sequential execution with flag writes
    for (int i = 0; i < 10; i++)
      step("R2_R8", 0, 0, 0, 0, $urandom % 16, $urandom % 16);

    // R3: taken transfers
    step("R3", 0, 1, 200, 0, 0, 0);
    step("R3", 0, 1, 17, 0, 3, 1);
    step("R3", 0, 1, 250, 0, 0, 0);

    // R2: wrap from the top address back to 0
    for (int i = 0; i < 12; i++)
      step("R2", 0, 0, 9, 0, $urandom % 16, $urandom % 16);

    // R6 / R7: keep executing past counter saturation
    for (int i = 0; i < 50; i++)
      step("R6_R7", 0, (i % 7) == 3, $urandom % 256, 0, $urandom % 16, $urandom % 16);
    check("R7", "saturated count", int'(instrCount), CNT_TOP);

    // R4: halt together with a taken transfer; halt wins and is counted
    step("R9", 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++)
      step("R2", 0, 0, 0, 0, 0, 0);
    step("R4_R6_R8", 0, 1, 99, 1, 15, 6);
    check("R6", "count incl halt", int'(instrCount), 6);
    check("R4", "pc held at halt", int'(pc), 5);

    // R5: everything ignored while halted
    for (int i = 0; i < 10; i++)
      step("R5", 0, $urandom % 2, $urandom % 256, $urandom % 2, 15, $urandom % 16);

    // R9: reset clears a halted state, execution resumes at 0
    step("R9", 1, 1, 40, 1, 15, 15);
    check("R9", "halted cleared", int'(halted), 0);
    step("R9", 0, 0, 0, 0, 0, 0);
    step("R9", 0, 1, 128, 0, 1, 1);
    step("R9", 0, 0, 0, 1, 0, 0);
    step("R5", 0, 1, 3, 0, 15, 0);

    done = 1;
    finishUp();
  end

endmodule